// File: doc/BRIEF.md
# Packet Transmit FIFO Controller

This block buffers outgoing payload bytes from a host and streams them as a packet toward a bit serializer. Storage is a 128-byte FIFO. Its fill-level flag compares the level against an offset taken from a programmed threshold, so the host knows when to refill. After the FIFO has been prefilled, a start strobe launches a packet. The engine first sends a fixed header of four preamble bytes and two sync bytes. It then drains the FIFO one byte per serializer handshake.

Two length modes are supported. In unbounded mode the packet runs for as long as the FIFO supplies bytes. In fixed mode the packet ends when the low 8 bits of a 16-bit payload counter equal the length register. Because the comparison uses only the low 8 bits, software can send a long packet in unbounded mode and then, before the tail, load the total size modulo 256 and switch to fixed mode. The packet then ends on the correct byte.

Errors are sticky. A FIFO that runs dry during the payload raises the underflow flag. A write to a full FIFO raises the overflow flag. Either error stops the packet, and only a flush strobe recovers from it.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After reset, thr_flag, pkt_active, err_under, err_over and ser_valid are all 0.
- R2: thr_flag is 1 exactly when the FIFO holds at least 127 - thr_cfg bytes. For thr_cfg = 120 the flag is 0 at 6 bytes and 1 at 7 bytes.
- R3: After start, the serializer receives 0xAA four times, then 0xD3, then 0x91, then the payload bytes in the order they were written.
- R4: With inf_mode = 1, payload keeps flowing past the byte count held in len_cfg, for as long as the FIFO has data.
- R5: With inf_mode = 0, the packet ends, and the engine returns to idle, on the payload byte whose running count has low 8 bits equal to len_cfg. inf_mode and len_cfg may be changed while the packet is in progress.
- R6: pkt_active rises on the cycle after the second sync byte is accepted. It is 0 during the header, and it falls after the last payload byte or on any error.
- R7: In fixed mode, a len_cfg of 0 yields a 256-byte payload.
- R8: If the FIFO is empty during the payload phase before the end condition, err_under sets, pkt_active falls and ser_valid drops.
- R9: While either error flag is set, a start strobe is ignored. Bytes written after an underflow stay queued until a flush removes them.
- R10: A write while 128 bytes are held sets err_over and discards the byte. It aborts a packet in progress. A flush clears both error flags and empties the FIFO.
- R11: While ser_valid is 1 and ser_ready is 0, ser_valid and ser_data hold their values, unless an overflow aborts the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| start | input | 1 | Start-of-packet strobe |
| flush | input | 1 | Empty the FIFO and clear the error flags |
| inf_mode | input | 1 | 1 = unbounded length, 0 = fixed length |
| len_cfg | input | 8 | Fixed-mode length, taken modulo 256 (0 means 256) |
| thr_cfg | input | 7 | Programmed threshold value |
| thr_flag | output | 1 | FIFO level is at least 127 - thr_cfg |
| pkt_active | output | 1 | Payload phase in progress |
| err_under | output | 1 | Sticky underflow flag |
| err_over | output | 1 | Sticky overflow flag |
| ser_data | output | 8 | Byte offered to the serializer |
| ser_valid | output | 1 | ser_data is valid |
| ser_ready | input | 1 | Serializer accepts the byte on this edge |

## Verification
On every cycle, the assertions check the following:
- the handshake data holds while stalled;
- errors silence the serializer port and pkt_active;
- pkt_active rises only right after an accepted header byte;
- underflow arises only from the payload phase;
- overflow is sticky;
- flush clears both errors.

Only the bench scenarios can show the byte order of header and payload and the exact packet length. That covers modulo-256 termination after a mid-packet mode switch, 256 bytes for a length of 0, and streaming past len_cfg in unbounded mode. The scenarios also cover the threshold crossing point for several thr_cfg values, and the fact that bytes discarded by overflow or dropped by flush never reach the serializer.

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo #(
  parameter int DW       = 8,
  parameter int DEPTH    = 128,
  parameter int LW       = 8,
  parameter int CW       = 16,
  parameter int PRE_N    = 4,
  parameter logic [DW-1:0] PRE_BYTE = 8'hAA,
  parameter logic [DW-1:0] SYNC_HI  = 8'hD3,
  parameter logic [DW-1:0] SYNC_LO  = 8'h91
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  input  logic          flush,
  input  logic          inf_mode,
  input  logic [LW-1:0] len_cfg,
  input  logic [$clog2(DEPTH)-1:0] thr_cfg,
  output logic          thr_flag,
  output logic          pkt_active,
  output logic          err_under,
  output logic          err_over,
  output logic [DW-1:0] ser_data,
  output logic          ser_valid,
  input  logic          ser_ready
);
  localparam int AW      = $clog2(DEPTH);
  localparam int NW      = AW + 1;
  localparam int HDR_LEN = PRE_N + 2;
  localparam int HW      = $clog2(HDR_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_ERR} st_t;

  st_t            st;
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [NW-1:0]  cnt;
  logic [HW-1:0]  hidx;
  logic [CW-1:0]  bcnt;
  logic [DW-1:0]  hdr_byte;

  wire full    = cnt == NW'(DEPTH);
  wire empty   = cnt == '0;
  wire wr_ovf  = wr_en && full;
  wire wr_ok   = wr_en && !full;
  wire xfer    = ser_valid && ser_ready;
  wire pop     = xfer && st == S_PAY;
  wire [CW-1:0] bcnt_nx = bcnt + 1'b1;
  wire pay_end = !inf_mode && (bcnt_nx[LW-1:0] == len_cfg);

  always_comb begin
    if (hidx < HW'(PRE_N))        hdr_byte = PRE_BYTE;
    else if (hidx == HW'(PRE_N))  hdr_byte = SYNC_HI;
    else                          hdr_byte = SYNC_LO;
  end

  assign thr_flag   = cnt >= (NW'(DEPTH - 1) - NW'(thr_cfg));
  assign pkt_active = st == S_PAY;
  assign ser_valid  = (st == S_HDR) || (st == S_PAY && !empty);
  assign ser_data   = (st == S_HDR) ? hdr_byte : mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok && !flush) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wp <= '0; rp <= '0; cnt <= '0;
      hidx <= '0; bcnt <= '0; err_under <= 1'b0; err_over <= 1'b0;
    end else if (flush) begin
      st <= S_IDLE; wp <= '0; rp <= '0; cnt <= '0;
      hidx <= '0; err_under <= 1'b0; err_over <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (pop)   rp <= rp + 1'b1;
      cnt <= cnt + NW'(wr_ok) - NW'(pop);
      if (wr_ovf) err_over <= 1'b1;
      case (st)
        S_IDLE:
          if (start && !err_under && !err_over && !wr_ovf) begin
            st <= S_HDR; hidx <= '0; bcnt <= '0;
          end
        S_HDR:
          if (wr_ovf) st <= S_ERR;
          else if (xfer) begin
            hidx <= hidx + 1'b1;
            if (hidx == HW'(HDR_LEN - 1)) st <= S_PAY;
          end
        S_PAY:
          if (wr_ovf) st <= S_ERR;
          else if (pop) begin
            bcnt <= bcnt_nx;
            if (pay_end) st <= S_IDLE;
          end else if (empty) begin
            st <= S_ERR; err_under <= 1'b1;
          end
        default: st <= S_ERR;
      endcase
    end
  end
endmodule

// File: rtl/tx_pkt_fifo_chk.sv
module tx_pkt_fifo_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          ser_valid,
  input logic          ser_ready,
  input logic [DW-1:0] ser_data,
  input logic          pkt_active,
  input logic          err_under,
  input logic          err_over
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !ser_ready && !flush |=> (ser_valid && $stable(ser_data)) || err_over); // R11

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (err_under || err_over) |-> !ser_valid && !pkt_active); // R8

  AST_ACTIVE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_active) |-> $past(ser_valid && ser_ready)); // R6

  AST_UNDER_FROM_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_under) |-> $past(pkt_active) && !$past(ser_valid)); // R8

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !err_under && !err_over && !pkt_active); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_over && !flush |=> err_over); // R10
endmodule

bind tx_pkt_fifo tx_pkt_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ser_valid(ser_valid),
  .ser_ready(ser_ready), .ser_data(ser_data), .pkt_active(pkt_active),
  .err_under(err_under), .err_over(err_over)
);

// File: tb/sim_tx_pkt_fifo.sv
module sim_tx_pkt_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, flush = 0, inf_mode = 0, ser_ready = 1;
  logic [7:0] wr_data = 0, len_cfg = 0, ser_data;
  logic [6:0] thr_cfg = 7'd120;
  logic thr_flag, pkt_active, err_under, err_over, ser_valid;

  tx_pkt_fifo u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, ready_mode = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] model_q[$];
  bit live = 0;
  logic [7:0] seq = 8'h11;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    case (ready_mode)
      0: ser_ready = 1;
      1: ser_ready = (cyc % 3) != 0;
      default: ser_ready = 0;
    endcase
  end

  // monitor: scoreboard compare of every accepted byte (R3)
  always @(negedge clk) begin
    if (rst_n && ser_valid && ser_ready) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected byte", ser_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(ser_data == e, "R3 byte", ser_data, e);
      end
    end
  end

  task automatic burst(input int n, input bit model);
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = seq;
      if (model) begin
        if (live) exp_q.push_back(seq); else model_q.push_back(seq);
      end
      seq = seq * 8'd5 + 8'd3;
      @(posedge clk); #1;
    end
    wr_en = 0;
  endtask

  task automatic go();
    @(posedge clk); #1;
    start = 1;
    for (int i = 0; i < 4; i++) exp_q.push_back(8'hAA);
    exp_q.push_back(8'hD3); exp_q.push_back(8'h91);
    while (model_q.size() > 0) exp_q.push_back(model_q.pop_front());
    live = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1; flush = 1;
    @(posedge clk); #1; flush = 0;
    exp_q.delete(); model_q.delete(); live = 0;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); #2;
      if (exp_q.size() == 0 && !pkt_active) break;
    end
    repeat (3) @(negedge clk);
    live = 0;
  endtask

  task automatic feed(input int total, input bit fixed_end, input logic [7:0] lenv);
    int rem;
    burst(128, 1);
    go();
    rem = total - 128;
    while (rem > 0) begin
      int n;
      @(negedge clk);
      while (thr_flag) @(negedge clk);
      n = (rem > 122) ? 122 : rem;
      if (n == rem && fixed_end) begin inf_mode = 0; len_cfg = lenv; end
      burst(n, 1);
      rem -= n;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    chk({thr_flag, pkt_active, err_under, err_over, ser_valid} == 0, "R1 reset",
        {thr_flag, pkt_active, err_under, err_over, ser_valid}, 0);
    rst_n = 1;

    // R2 threshold crossing
    burst(6, 0); @(negedge clk);
    chk(thr_flag == 0, "R2 six bytes", thr_flag, 0);
    burst(1, 0); @(negedge clk);
    chk(thr_flag == 1, "R2 seven bytes", thr_flag, 1);
    thr_cfg = 7'd0; @(negedge clk);
    chk(thr_flag == 0, "R2 thr 0", thr_flag, 0);
    thr_cfg = 7'd126; @(negedge clk);
    chk(thr_flag == 1, "R2 thr 126", thr_flag, 1);
    thr_cfg = 7'd120;
    do_flush();

    // R3 R6 R11 short fixed packet with backpressure
    ready_mode = 1; inf_mode = 0; len_cfg = 8'd10;
    burst(10, 1);
    go();
    @(negedge clk);
    chk(pkt_active == 0, "R6 header inactive", pkt_active, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #2;
      if (exp_q.size() == 10) break;
    end
    @(negedge clk);
    chk(pkt_active == 1, "R6 active after sync", pkt_active, 1);
    wait_done(400);
    chk(exp_q.size() == 0 && !pkt_active && !err_under, "R5 fixed 10 done", exp_q.size(), 0);
    ready_mode = 0;

    // R4 infinite: runs past len_cfg until the FIFO is empty
    inf_mode = 1; len_cfg = 8'd5;
    feed(300, 0, 8'd0);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (err_under) break; end
    chk(exp_q.size() == 0, "R4 all 300 sent", exp_q.size(), 0);
    chk(err_under == 1 && pkt_active == 0, "R8 underflow at drain", err_under, 1);
    do_flush();

    // R5 long packet ended by switching to fixed mode (300 mod 256 = 44)
    inf_mode = 1; len_cfg = 8'd0;
    feed(300, 1, 8'd44);
    wait_done(600);
    chk(exp_q.size() == 0 && !err_under && !pkt_active, "R5 switch end", err_under, 0);

    // R7 length 0 means 256
    inf_mode = 0; len_cfg = 8'd0;
    feed(256, 0, 8'd0);
    wait_done(600);
    chk(exp_q.size() == 0 && !err_under, "R7 256 bytes", exp_q.size(), 0);
    chk(ser_valid == 0 && thr_flag == 0, "R7 idle empty", ser_valid, 0);

    // R8 R9 underflow mid packet, leftover needs flush
    len_cfg = 8'd20;
    burst(5, 1);
    go();
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (err_under) break; end
    chk(err_under == 1 && pkt_active == 0 && ser_valid == 0, "R8 underflow", err_under, 1);
    chk(exp_q.size() == 0, "R8 bytes before underflow", exp_q.size(), 0);
    live = 0;
    burst(2, 0);
    @(posedge clk); #1; start = 1; @(posedge clk); #1; start = 0;
    repeat (10) @(negedge clk);
    chk(ser_valid == 0 && err_under == 1, "R9 start ignored", ser_valid, 0);
    do_flush();
    @(negedge clk);
    chk(err_under == 0, "R9 flush clears", err_under, 0);
    len_cfg = 8'd3;
    burst(3, 1); go(); wait_done(100);
    chk(exp_q.size() == 0 && !err_under, "R9 leftover dropped", exp_q.size(), 0);

    // R10 overflow while idle
    burst(128, 1);
    @(negedge clk);
    chk(thr_flag == 1 && err_over == 0, "R10 full no error", err_over, 0);
    burst(1, 0);
    @(negedge clk);
    chk(err_over == 1, "R10 overflow set", err_over, 1);
    @(posedge clk); #1; start = 1; @(posedge clk); #1; start = 0;
    repeat (5) @(negedge clk);
    chk(ser_valid == 0 && err_over == 1, "R10 start ignored", ser_valid, 0);
    do_flush();
    @(negedge clk);
    chk(err_over == 0 && thr_flag == 0, "R10 flush empties", err_over, 0);
    len_cfg = 8'd4;
    burst(4, 1); go(); wait_done(100);
    chk(exp_q.size() == 0, "R10 discarded byte not sent", exp_q.size(), 0);

    // R10 overflow aborts a stalled packet
    ready_mode = 2;
    burst(128, 1); go();
    repeat (3) @(negedge clk);
    chk(ser_valid == 1 && pkt_active == 0, "R11 stalled header", ser_valid, 1);
    burst(1, 0);
    @(negedge clk);
    chk(err_over == 1 && ser_valid == 0, "R10 abort", ser_valid, 0);
    do_flush();
    ready_mode = 0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule